// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block keeps a 64K x 16 asynchronous DRAM alive. After reset it holds off for a power-up pause. It then runs a burst of wake-up refresh cycles and only then reports the memory as usable. From then on an interval timer makes one refresh due every `INTERVAL_CYC` clocks, which keeps the whole array within its 256-rows-per-4-ms retention budget. Every refresh is a CAS-before-RAS cycle, so the DRAM supplies the row address from its own counter and the address bus plays no part.

The sequencer shares the DRAM control pins with an access controller, which is not part of this block. When a refresh is wanted it raises `req_o`. It starts a cycle only on a clock edge where `grant_i` is also high. It keeps `req_o` high until the cycle, precharge included, is over. Refreshes that cannot be started at once are owed in a bounded debt counter. If a refresh falls due while the debt is already at its limit, the retention deadline is taken as lost. The block pulses `missed_o`, drops `ready_o` and repeats the wake-up burst.

Timings are whole clock cycles set by parameters:
- `T_CSR`: column strobes fall this long before the row strobe.
- `T_CHR`: column strobes stay low this long after the row strobe falls.
- `T_RAS`: length of the row strobe low pulse.
- `T_RP` and `T_RPC`: precharge. Their maximum, T_PRE, is the precharge time the block uses.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n_o`, `casl_n_o`, `cash_n_o` and `we_n_o` are 1, and `req_o`, `ready_o` and `missed_o` are 0.
- R2: After reset is released, no request and no strobe appear for `PWRUP_CYC` clock edges; `req_o` is first high after edge number `PWRUP_CYC`.
- R3: After the pause, `WAKE_CNT` refresh cycles are run with `ready_o` at 0; `ready_o` becomes 1 exactly T_PRE clock edges after the row strobe of the last wake-up cycle rises.
- R4: In every cycle both column strobes fall together and stay low for exactly `T_CSR` cycles while the row strobe is high. The row strobe then falls, and the column strobes stay low for exactly `T_CHR` more cycles.
- R5: The row strobe is low for exactly `T_RAS` cycles per refresh, and `we_n_o` is 1 when it falls.
- R6: After the row strobe rises, both strobes stay high for at least T_PRE cycles before any column strobe falls again.
- R7: A refresh cycle begins only on an edge where `req_o` and `grant_i` are both 1. `req_o` stays 1 until that cycle ends, and no strobe is ever low while `req_o` is 0.
- R8: Once ready, with `grant_i` held at 1, successive row strobe falls are exactly `INTERVAL_CYC` cycles apart.
- R9: Up to `MAX_DEBT` due refreshes are kept while grant is withheld, with `ready_o` staying 1. On grant they run back to back, one row strobe fall every T_CSR+T_RAS+T_PRE+1 cycles.
- R10: A refresh falling due with `MAX_DEBT` already owed pulses `missed_o` for one cycle. It clears the debt and drops `ready_o` on the next edge. It then runs `WAKE_CNT` wake-up cycles before `ready_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all timing counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | Access side allows a refresh cycle to start |
| req_o | output | 1 | Refresh wanted or in progress; access side keeps off the bus |
| ras_n_o | output | 1 | Row strobe, active low |
| casl_n_o | output | 1 | Lower byte column strobe, active low |
| cash_n_o | output | 1 | Upper byte column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| ready_o | output | 1 | Memory initialised and refresh on schedule |
| missed_o | output | 1 | One-cycle pulse when the refresh deadline is lost |

## Verification
The assertions take `grant_i` to be an ordinary level, sampled at clock edges. They rely on the sequencer owning the strobes whenever `req_o` is high and never on the access side driving them. The timing parameters are assumed to satisfy `T_RAS > T_CHR` and to be nonzero, which elaboration checks enforce. The bench changes `grant_i` only at falling clock edges. It holds grant low only in windows measured against the refresh schedule: one window long enough to build up the full debt without a miss, and a longer one that forces exactly one miss.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
   typedef enum logic [2:0] {
      CY_IDLE,
      CY_SETUP,
      CY_ACT,
      CY_HOLD,
      CY_PRE
   } cyc_state_t;

   typedef enum logic [1:0] {
      MD_PAUSE,
      MD_WAKE,
      MD_RUN
   } seq_mode_t;
endpackage

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
   import dram_rfsh_pkg::*;
#(
   parameter int T_CSR = 1,
   parameter int T_CHR = 1,
   parameter int T_RAS = 3,
   parameter int T_PRE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o,
   output logic ras_n_o,
   output logic cas_n_o
);
   localparam int M1   = (T_CSR > T_CHR) ? T_CSR : T_CHR;
   localparam int M2   = (T_RAS > T_PRE) ? T_RAS : T_PRE;
   localparam int MAXV = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXV + 1);

   initial begin
      assert (T_CSR >= 1 && T_CHR >= 1 && T_PRE >= 1)
         else $error("cycle phases must be at least one clock");
      assert (T_RAS > T_CHR)
         else $error("row strobe must outlast the column hold");
   end

   cyc_state_t      state;
   logic [CW-1:0]   cnt;
   logic            cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CY_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            CY_IDLE: if (start_i) begin
               state <= CY_SETUP;
               cnt   <= CW'(T_CSR - 1);
            end
            CY_SETUP: if (cnt_zero) begin
               state <= CY_ACT;
               cnt   <= CW'(T_CHR - 1);
            end else cnt <= cnt - 1'b1;
            CY_ACT: if (cnt_zero) begin
               state <= CY_HOLD;
               cnt   <= CW'(T_RAS - T_CHR - 1);
            end else cnt <= cnt - 1'b1;
            CY_HOLD: if (cnt_zero) begin
               state <= CY_PRE;
               cnt   <= CW'(T_PRE - 1);
            end else cnt <= cnt - 1'b1;
            CY_PRE: if (cnt_zero) state <= CY_IDLE;
               else cnt <= cnt - 1'b1;
            default: state <= CY_IDLE;
         endcase
      end
   end

   assign busy_o  = (state != CY_IDLE);
   assign done_o  = (state == CY_PRE) && cnt_zero;
   assign ras_n_o = !((state == CY_ACT) || (state == CY_HOLD));
   assign cas_n_o = !((state == CY_SETUP) || (state == CY_ACT));

   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> !cas_n_o);
   // R4
   cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n_o) |-> ras_n_o);
endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
   parameter int INTERVAL_CYC = 1560,
   parameter int MAX_DEBT     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic done_i,
   output logic owed_o,
   output logic miss_o
);
   localparam int TW = $clog2(INTERVAL_CYC);
   localparam int DW = $clog2(MAX_DEBT + 1);

   initial begin
      assert (INTERVAL_CYC >= 2) else $error("interval too short");
      assert (MAX_DEBT >= 1) else $error("debt limit must be positive");
   end

   logic [TW-1:0] tmr;
   logic [DW-1:0] debt;
   logic          tick;
   logic          full;

   assign tick   = run_i && (tmr == '0);
   assign full   = (debt == DW'(MAX_DEBT));
   assign miss_o = tick && !done_i && full;
   assign owed_o = (debt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         tmr  <= TW'(INTERVAL_CYC - 1);
         debt <= '0;
      end else begin
         tmr <= tick ? TW'(INTERVAL_CYC - 1) : tmr - 1'b1;
         case ({tick, done_i})
            2'b10: debt <= full ? '0 : debt + 1'b1;
            2'b01: if (debt != '0) debt <= debt - 1'b1;
            default: debt <= debt;
         endcase
      end
   end

   // R9
   debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DW'(MAX_DEBT));
   // R10
   miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |=> (debt == '0));
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int PWRUP_CYC    = 20000,
   parameter int INTERVAL_CYC = 1560,
   parameter int MAX_DEBT     = 8,
   parameter int WAKE_CNT     = 8,
   parameter int T_CSR        = 1,
   parameter int T_CHR        = 1,
   parameter int T_RAS        = 3,
   parameter int T_RP         = 2,
   parameter int T_RPC        = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   output logic req_o,
   output logic ras_n_o,
   output logic casl_n_o,
   output logic cash_n_o,
   output logic we_n_o,
   output logic ready_o,
   output logic missed_o
);
   localparam int T_PRE = (T_RP > T_RPC) ? T_RP : T_RPC;
   localparam int PW    = $clog2(PWRUP_CYC);
   localparam int BW    = $clog2(WAKE_CNT + 1);

   initial begin
      assert (PWRUP_CYC >= 2) else $error("power-up pause too short");
      assert (WAKE_CNT >= 1) else $error("wake-up burst must be nonempty");
   end

   seq_mode_t     mode;
   logic [PW-1:0] pcnt;
   logic [BW-1:0] burst;
   logic          busy, done, cas_n, owed, miss, need, start, run_done;

   assign need     = (mode == MD_WAKE) || ((mode == MD_RUN) && owed);
   assign start    = need && grant_i && !busy;
   assign run_done = done && (mode == MD_RUN);

   rfsh_cycle_fsm #(
      .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_PRE(T_PRE)
   ) u_cyc (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
      .done_o(done), .ras_n_o(ras_n_o), .cas_n_o(cas_n)
   );

   rfsh_pacer #(
      .INTERVAL_CYC(INTERVAL_CYC), .MAX_DEBT(MAX_DEBT)
   ) u_pace (
      .clk(clk), .rst_n(rst_n), .run_i(mode == MD_RUN),
      .done_i(run_done), .owed_o(owed), .miss_o(miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode  <= MD_PAUSE;
         pcnt  <= PW'(PWRUP_CYC - 1);
         burst <= BW'(WAKE_CNT);
      end else begin
         case (mode)
            MD_PAUSE: if (pcnt == '0) begin
               mode  <= MD_WAKE;
               burst <= BW'(WAKE_CNT);
            end else pcnt <= pcnt - 1'b1;
            MD_WAKE: if (done) begin
               if (burst == BW'(1)) mode <= MD_RUN;
               burst <= burst - 1'b1;
            end
            MD_RUN: if (miss) begin
               mode  <= MD_WAKE;
               burst <= BW'(WAKE_CNT);
            end
            default: mode <= MD_PAUSE;
         endcase
      end
   end

   assign req_o    = need || busy;
   assign casl_n_o = cas_n;
   assign cash_n_o = cas_n;
   assign we_n_o   = 1'b1;
   assign ready_o  = (mode == MD_RUN);
   assign missed_o = miss;

   // R7
   strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n_o || !casl_n_o) |-> req_o);
   // R7
   start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(grant_i));
   // R2
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PAUSE) |-> (!req_o && ras_n_o && casl_n_o));
   // R10
   miss_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      missed_o |=> !ready_o);
endmodule

// File: tb/tb_dram_rfsh_seq.sv
module tb_dram_rfsh_seq;
   localparam int CLK_PERIOD = 10;
   localparam int P   = 40;
   localparam int IV  = 50;
   localparam int MD  = 2;
   localparam int W   = 8;
   localparam int CSR = 2;
   localparam int CHR = 3;
   localparam int RAS = 6;
   localparam int RP  = 4;
   localparam int RPC = 3;
   localparam int PRE = (RP > RPC) ? RP : RPC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grant = 1'b1;
   logic req, ras_n, casl_n, cash_n, we_n, ready, missed;

   dram_rfsh_seq #(
      .PWRUP_CYC(P), .INTERVAL_CYC(IV), .MAX_DEBT(MD), .WAKE_CNT(W),
      .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP), .T_RPC(RPC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .grant_i(grant), .req_o(req),
      .ras_n_o(ras_n), .casl_n_o(casl_n), .cash_n_o(cash_n),
      .we_n_o(we_n), .ready_o(ready), .missed_o(missed)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit done_flag = 0;
   bit exp_q[$];          // expected ready_o at each row strobe fall
   int cyc = 0;
   int rises = 0;
   int miss_seen = 0;
   bit quiet_viol = 0;
   bit spc_on = 0;
   bit have_prev = 0;
   int fall_prev = 0, fall_last = 0;

   task automatic chk(bit ok, string req_tag, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req_tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic push_items(int n, bit rdy);
      for (int i = 0; i < n; i++) exp_q.push_back(rdy);
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: measures each refresh cycle at falling edges, pops expectation
   bit pr = 1, pc = 1, seen_rise = 0;
   int setup_n = 0, low_n = 0, hold_n = 0, gap_n = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         pr = 1; pc = 1;
      end else begin
         if (!req && (!ras_n || !casl_n || !cash_n)) quiet_viol = 1;
         if (missed) miss_seen++;
         if (pc && !casl_n) begin
            if (seen_rise) chk(gap_n >= PRE, "R6", "precharge gap", gap_n, PRE);
            chk(cash_n == casl_n, "R4", "column strobes together", cash_n, casl_n);
            setup_n = 1;
         end else if (!casl_n && ras_n) setup_n++;
         if (pr && !ras_n) begin
            chk(setup_n == CSR, "R4", "cas setup cycles", setup_n, CSR);
            chk(we_n == 1'b1, "R5", "we_n at row fall", we_n, 1);
            if (exp_q.size() == 0) chk(0, "R7", "unexpected refresh", 1, 0);
            else begin
               bit e;
               e = exp_q.pop_front();
               chk(ready == e, "R3", "ready during cycle", ready, e);
            end
            if (spc_on && have_prev)
               chk(cyc - fall_last == IV, "R8", "refresh spacing", cyc - fall_last, IV);
            have_prev = spc_on;
            fall_prev = fall_last;
            fall_last = cyc;
            low_n = 1;
            hold_n = casl_n ? 0 : 1;
         end else if (!ras_n) begin
            low_n++;
            if (!casl_n) hold_n++;
         end
         if (!pr && ras_n) begin
            chk(low_n == RAS, "R5", "row strobe width", low_n, RAS);
            chk(hold_n == CHR, "R4", "cas hold cycles", hold_n, CHR);
            seen_rise = 1;
            gap_n = 1;
            rises++;
         end else if (ras_n && casl_n) gap_n++;
         pr = ras_n;
         pc = casl_n;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "R7", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ras_n && casl_n && cash_n && we_n, "R1", "strobes high in reset",
          {ras_n, casl_n, cash_n, we_n}, 15);
      chk(!req && !ready && !missed, "R1", "outputs low in reset",
          {req, ready, missed}, 0);
      push_items(W, 1'b0);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!req && n < 1000);
      chk(n == P, "R2", "pause length", n, P);
      chk(rises == 0, "R2", "no refresh during pause", rises, 0);

      // R3 wake-up burst and ready
      wait (rises == W);
      repeat (PRE - 1) @(negedge clk);
      chk(ready == 1'b0, "R3", "ready before burst completes", ready, 0);
      @(negedge clk);
      chk(ready == 1'b1, "R3", "ready after burst", ready, 1);

      // R8 steady pacing with grant held
      spc_on = 1;
      push_items(3, 1'b1);
      wait (rises == W + 3);
      spc_on = 0;

      // R9 debt without miss
      grant = 1'b0;
      push_items(3, 1'b1);
      repeat (120) @(negedge clk);
      chk(req == 1'b1, "R7", "request held while not granted", req, 1);
      chk(ras_n == 1'b1, "R7", "no cycle without grant", ras_n, 1);
      chk(ready == 1'b1, "R9", "ready kept with debt", ready, 1);
      chk(miss_seen == 0, "R9", "no miss within debt limit", miss_seen, 0);
      grant = 1'b1;
      wait (rises == W + 5);
      chk(fall_last - fall_prev == CSR + RAS + PRE + 1, "R9",
          "back to back spacing", fall_last - fall_prev, CSR + RAS + PRE + 1);
      wait (rises == W + 6);

      // R10 missed deadline
      grant = 1'b0;
      push_items(W, 1'b0);
      repeat (200) @(negedge clk);
      chk(miss_seen == 1, "R10", "single miss pulse", miss_seen, 1);
      chk(ready == 1'b0, "R10", "ready dropped after miss", ready, 0);
      chk(req == 1'b1, "R10", "wake-up requested", req, 1);
      grant = 1'b1;
      wait (rises == 2 * W + 6);
      repeat (PRE) @(negedge clk);
      chk(ready == 1'b1, "R10", "ready restored", ready, 1);
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all expected cycles seen", exp_q.size(), 0);
      chk(!quiet_viol, "R7", "strobes only under request", quiet_viol, 0);
      finish_run();
   end
endmodule